// File: doc/BRIEF.md
# Console and Boot-Information Register Block

This block is a memory-mapped device that lets boot firmware and an operating system find out about the platform, move characters to and from a console, issue disk read requests and start secondary processors. It sits on a simple single-cycle bus. Each access presents an offset, a read or write strobe, a size in bytes and write data. The block answers one cycle later with a valid flag, an error flag and read data.

Platform parameters are captured from input ports on a one-cycle load pulse and are read-only to software. These are the processor count, the interrupt clock rate, the memory size, the processor clock in MHz and the kernel start, end and entry addresses.

Disk-request registers are writable. Writing the read command to the operation register launches a request on a strobe-and-data interface. A write to the output-character register emits a byte on an output stream. A read of the input-character register pops a byte from an input stream. A table of per-processor start values turns each nonzero write into a launch request for that processor.

The response path is a small state machine with four named states:
- `ST_IDLE`: no response is pending.
- `ST_RDACK`: a legal read is being answered.
- `ST_WRACK`: a legal write is being acknowledged.
- `ST_FAULT`: a rejected access is being reported.

Every cycle the machine moves to the state chosen by the access presented in that cycle:
- no access leads to `ST_IDLE`;
- a legal read leads to `ST_RDACK`;
- a legal write leads to `ST_WRACK`;
- anything else leads to `ST_FAULT`.

Any state can reach any other.

Top module: `cons_regblk`

## Requirements
- R1: After reset, reads return the following values:
  - offset 0x00 (4 bytes) returns 0x26F, the window size minus one;
  - offset 0x04 (4 bytes) returns the VERSION parameter;
  - disk unit (0x38) returns 1;
  - disk count (0x40), disk address (0x48), disk block (0x50), disk operation (0x58), output character (0x60) and every table entry (0x70 + 8*i) return 0;
  - all platform parameters return 0 until loaded.
- R2: Every cycle with `bus_rd` or `bus_wr` high is answered by `rsp_valid` high in the next cycle. With neither strobe high, `rsp_valid` is low in the next cycle. `rsp_err` is high only together with `rsp_valid`.
- R3: A 4-byte read is legal only at offsets 0x00, 0x04, 0x08 (processor count) and 0x0C (interrupt clock). A 4-byte read anywhere else is an error.
- R4: Other accesses are errors:
  - a read of 8 bytes at offsets 0x00 to 0x0C;
  - any size other than 4 or 8;
  - an offset of 0x270 or above;
  - a misaligned 8-byte offset;
  - `bus_rd` and `bus_wr` high together.
- R5: Writes must be 8 bytes, to disk unit, disk count, disk address, disk block, disk operation, output character or a table entry. Any other write is an error.
- R6: Writing 0x13 to disk operation pulses `dsk_go` for one cycle. `dsk_paddr`, `dsk_block` and `dsk_count` carry the register values current at that write and are held until the next request. Any other value written there is an error.
- R7: An 8-byte write to 0x60 pulses `tty_out_vld` for one cycle with `tty_out_byte` equal to bits 7:0 of the write data. Reads of 0x60 return 0.
- R8: An 8-byte read of 0x68 returns `tty_in_byte` (zero-extended) as sampled in the access cycle, and pulses `tty_in_pop` for one cycle.
- R9: Table entry i (i = 0 to 63) sits at offset 0x70 + 8*i.
  - A nonzero 8-byte write stores the value and pulses `cpu_go` with `cpu_go_idx` = i and `cpu_go_val` = the value.
  - A write of zero is an error.
- R10: A one-cycle `prm_load` pulse captures all `prm_*` inputs into the read-only parameter registers. Processor count and interrupt clock are 4-byte fields at 0x08 and 0x0C. Memory size, processor MHz, kernel start, kernel end and kernel entry are 8-byte fields at 0x10, 0x18, 0x20, 0x28 and 0x30.
- R11: A faulting access changes no register. It produces none of `dsk_go`, `cpu_go`, `tty_out_vld` or `tty_in_pop`.
- R12: The disk-request registers read back the last legally written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 10 | Byte offset within the window |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Previous access was rejected |
| rsp_rdata | output | 64 | Read data, zero unless a read succeeded |
| prm_load | input | 1 | Capture pulse for platform parameters |
| prm_ncpu | input | 32 | Processor count |
| prm_intr_hz | input | 32 | Interrupt clock frequency |
| prm_mem_bytes | input | 64 | Memory size |
| prm_cpu_mhz | input | 64 | Processor clock in MHz |
| prm_kern_start | input | 64 | Kernel start address |
| prm_kern_end | input | 64 | Kernel end address |
| prm_kern_entry | input | 64 | Kernel entry address |
| tty_out_vld | output | 1 | Output character strobe |
| tty_out_byte | output | 8 | Output character |
| tty_in_pop | output | 1 | Input character consumed |
| tty_in_byte | input | 8 | Next input character |
| dsk_go | output | 1 | Disk read request strobe |
| dsk_paddr | output | 64 | Request destination address |
| dsk_block | output | 64 | Request starting block |
| dsk_count | output | 64 | Request block count |
| cpu_go | output | 1 | Processor launch strobe |
| cpu_go_idx | output | 6 | Launched processor index |
| cpu_go_val | output | 64 | Start value for the launched processor |

## Verification
A corrupted response state shows at the ports on the very next cycle. It appears as a missing or spurious `rsp_valid`, or an error flag on a legal access. A wrong stored disk, table or parameter value stays hidden until software reads it back or a launch strobe carries it. For that reason the bench follows every kind of write with reads and compares each request strobe's arguments. A fault that still updates state is exposed by the readback that follows the faulting access.

// File: rtl/cons_pkg.sv
package cons_pkg;
    localparam int unsigned ADDR_W    = 10;
    localparam int unsigned DATA_W    = 64;
    localparam int unsigned CPU_N     = 64;
    localparam int unsigned CPU_IDX_W = $clog2(CPU_N);
    localparam int unsigned SIZE_W    = 4;

    localparam logic [ADDR_W-1:0] OFF_LAST      = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_VER       = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_NCPU      = 10'h008;
    localparam logic [ADDR_W-1:0] OFF_INTR      = 10'h00C;
    localparam logic [ADDR_W-1:0] OFF_WIDE_BASE = 10'h010;
    localparam logic [ADDR_W-1:0] OFF_TAB_BASE  = 10'h070;
    localparam int unsigned       WIN_BYTES     = 32'h70 + CPU_N * 8;
    localparam logic [ADDR_W-1:0] OFF_WIN_END   = ADDR_W'(WIN_BYTES);

    localparam logic [DATA_W-1:0] DISK_READ_CMD = 64'h13;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_LAST, SEL_VER, SEL_NCPU, SEL_INTR,
        SEL_MEM, SEL_CPUCLK, SEL_KSTART, SEL_KEND, SEL_ENTRY,
        SEL_DUNIT, SEL_DCOUNT, SEL_DPADDR, SEL_DBLOCK, SEL_DOP,
        SEL_OUTCH, SEL_INCH, SEL_CPUTAB
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RDACK, ST_WRACK, ST_FAULT
    } rsp_state_e;
endpackage

// File: rtl/cons_decode.sv
module cons_decode
    import cons_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic [SIZE_W-1:0]    size,
    input  logic                 is_wr,
    output reg_sel_e             sel,
    output logic [CPU_IDX_W-1:0] tab_idx,
    output logic                 legal
);
    logic [ADDR_W-1:0] wide_off;
    logic [ADDR_W-1:0] tab_off;
    logic              narrow;
    logic              writable;
    logic              aligned8;

    always_comb begin
        wide_off = addr - OFF_WIDE_BASE;
        tab_off  = addr - OFF_TAB_BASE;
        tab_idx  = tab_off[3 +: CPU_IDX_W];
        aligned8 = (addr[2:0] == 3'd0);
        sel      = SEL_NONE;
        if (addr == OFF_LAST)      sel = SEL_LAST;
        else if (addr == OFF_VER)  sel = SEL_VER;
        else if (addr == OFF_NCPU) sel = SEL_NCPU;
        else if (addr == OFF_INTR) sel = SEL_INTR;
        else if (addr >= OFF_WIDE_BASE && addr < OFF_TAB_BASE && aligned8) begin
            unique case (wide_off[6:3])
                4'd0:    sel = SEL_MEM;
                4'd1:    sel = SEL_CPUCLK;
                4'd2:    sel = SEL_KSTART;
                4'd3:    sel = SEL_KEND;
                4'd4:    sel = SEL_ENTRY;
                4'd5:    sel = SEL_DUNIT;
                4'd6:    sel = SEL_DCOUNT;
                4'd7:    sel = SEL_DPADDR;
                4'd8:    sel = SEL_DBLOCK;
                4'd9:    sel = SEL_DOP;
                4'd10:   sel = SEL_OUTCH;
                4'd11:   sel = SEL_INCH;
                default: sel = SEL_NONE;
            endcase
        end
        else if (addr >= OFF_TAB_BASE && addr < OFF_WIN_END && aligned8) sel = SEL_CPUTAB;
    end

    assign narrow   = (sel == SEL_LAST) || (sel == SEL_VER) ||
                      (sel == SEL_NCPU) || (sel == SEL_INTR);
    assign writable = (sel == SEL_DUNIT) || (sel == SEL_DCOUNT) || (sel == SEL_DPADDR) ||
                      (sel == SEL_DBLOCK) || (sel == SEL_DOP) || (sel == SEL_OUTCH) ||
                      (sel == SEL_CPUTAB);

    always_comb begin
        if (is_wr) legal = (size == SIZE_W'(8)) && writable;
        else       legal = ((size == SIZE_W'(4)) && narrow) ||
                           ((size == SIZE_W'(8)) && (sel != SEL_NONE) && !narrow);
    end
endmodule

// File: rtl/cons_cpu_table.sv
module cons_cpu_table #(
    parameter int unsigned N = 64,
    parameter int unsigned W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [W-1:0]         wr_data,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic [W-1:0]         rd_data,
    output logic                 go,
    output logic [$clog2(N)-1:0] go_idx,
    output logic [W-1:0]         go_val
);
    localparam int unsigned IDX_W = $clog2(N);

    logic [W-1:0] ent_q [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   ent_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))        ent_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go     <= 1'b0;
            go_idx <= '0;
            go_val <= '0;
        end else begin
            go <= wr_en;
            if (wr_en) begin
                go_idx <= wr_idx;
                go_val <= wr_data;
            end
        end
    end

    assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/cons_regblk.sv
module cons_regblk
    import cons_pkg::*;
#(
    parameter logic [31:0] VERSION = 32'h0000_0009
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [SIZE_W-1:0]    bus_size,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 prm_load,
    input  logic [31:0]          prm_ncpu,
    input  logic [31:0]          prm_intr_hz,
    input  logic [DATA_W-1:0]    prm_mem_bytes,
    input  logic [DATA_W-1:0]    prm_cpu_mhz,
    input  logic [DATA_W-1:0]    prm_kern_start,
    input  logic [DATA_W-1:0]    prm_kern_end,
    input  logic [DATA_W-1:0]    prm_kern_entry,
    output logic                 tty_out_vld,
    output logic [7:0]           tty_out_byte,
    output logic                 tty_in_pop,
    input  logic [7:0]           tty_in_byte,
    output logic                 dsk_go,
    output logic [DATA_W-1:0]    dsk_paddr,
    output logic [DATA_W-1:0]    dsk_block,
    output logic [DATA_W-1:0]    dsk_count,
    output logic                 cpu_go,
    output logic [CPU_IDX_W-1:0] cpu_go_idx,
    output logic [DATA_W-1:0]    cpu_go_val
);
    localparam logic [31:0] LAST_OFF = 32'(WIN_BYTES - 1);

    rsp_state_e state_q, state_nxt;

    reg_sel_e             dec_sel;
    logic [CPU_IDX_W-1:0] dec_idx;
    logic                 dec_legal;
    logic                 acc_rd, acc_wr;
    logic [DATA_W-1:0]    rd_mux, rd_q, tab_rd;

    logic [31:0]       p_ncpu_q, p_intr_q;
    logic [DATA_W-1:0] p_mem_q, p_mhz_q, p_kst_q, p_ken_q, p_kent_q;
    logic [DATA_W-1:0] d_unit_q, d_count_q, d_paddr_q, d_block_q, d_op_q;

    cons_decode u_dec (
        .addr    (bus_addr),
        .size    (bus_size),
        .is_wr   (bus_wr),
        .sel     (dec_sel),
        .tab_idx (dec_idx),
        .legal   (dec_legal)
    );

    // next-state choice from the access in this cycle
    always_comb begin
        state_nxt = ST_IDLE;
        if (bus_rd && bus_wr)                                   state_nxt = ST_FAULT;
        else if (bus_rd)                                        state_nxt = dec_legal ? ST_RDACK : ST_FAULT;
        else if (bus_wr) begin
            if (!dec_legal)                                     state_nxt = ST_FAULT;
            else if (dec_sel == SEL_DOP && bus_wdata != DISK_READ_CMD) state_nxt = ST_FAULT;
            else if (dec_sel == SEL_CPUTAB && bus_wdata == '0)  state_nxt = ST_FAULT;
            else                                                state_nxt = ST_WRACK;
        end
    end

    assign acc_rd = (state_nxt == ST_RDACK);
    assign acc_wr = (state_nxt == ST_WRACK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // response outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RDACK: begin rsp_valid = 1'b1; rsp_rdata = rd_q; end
            ST_WRACK: rsp_valid = 1'b1;
            ST_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:  ;
        endcase
    end

    always_comb begin
        unique case (dec_sel)
            SEL_LAST:   rd_mux = {32'd0, LAST_OFF};
            SEL_VER:    rd_mux = {32'd0, VERSION};
            SEL_NCPU:   rd_mux = {32'd0, p_ncpu_q};
            SEL_INTR:   rd_mux = {32'd0, p_intr_q};
            SEL_MEM:    rd_mux = p_mem_q;
            SEL_CPUCLK: rd_mux = p_mhz_q;
            SEL_KSTART: rd_mux = p_kst_q;
            SEL_KEND:   rd_mux = p_ken_q;
            SEL_ENTRY:  rd_mux = p_kent_q;
            SEL_DUNIT:  rd_mux = d_unit_q;
            SEL_DCOUNT: rd_mux = d_count_q;
            SEL_DPADDR: rd_mux = d_paddr_q;
            SEL_DBLOCK: rd_mux = d_block_q;
            SEL_DOP:    rd_mux = d_op_q;
            SEL_INCH:   rd_mux = {{(DATA_W-8){1'b0}}, tty_in_byte};
            SEL_CPUTAB: rd_mux = tab_rd;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q         <= '0;
            p_ncpu_q     <= '0;
            p_intr_q     <= '0;
            p_mem_q      <= '0;
            p_mhz_q      <= '0;
            p_kst_q      <= '0;
            p_ken_q      <= '0;
            p_kent_q     <= '0;
            d_unit_q     <= DATA_W'(1);
            d_count_q    <= '0;
            d_paddr_q    <= '0;
            d_block_q    <= '0;
            d_op_q       <= '0;
            dsk_go       <= 1'b0;
            dsk_paddr    <= '0;
            dsk_block    <= '0;
            dsk_count    <= '0;
            tty_out_vld  <= 1'b0;
            tty_out_byte <= '0;
            tty_in_pop   <= 1'b0;
        end else begin
            dsk_go      <= 1'b0;
            tty_out_vld <= 1'b0;
            tty_in_pop  <= 1'b0;
            if (prm_load) begin
                p_ncpu_q <= prm_ncpu;
                p_intr_q <= prm_intr_hz;
                p_mem_q  <= prm_mem_bytes;
                p_mhz_q  <= prm_cpu_mhz;
                p_kst_q  <= prm_kern_start;
                p_ken_q  <= prm_kern_end;
                p_kent_q <= prm_kern_entry;
            end
            if (acc_rd) begin
                rd_q <= rd_mux;
                if (dec_sel == SEL_INCH) tty_in_pop <= 1'b1;
            end
            if (acc_wr) begin
                unique case (dec_sel)
                    SEL_DUNIT:  d_unit_q  <= bus_wdata;
                    SEL_DCOUNT: d_count_q <= bus_wdata;
                    SEL_DPADDR: d_paddr_q <= bus_wdata;
                    SEL_DBLOCK: d_block_q <= bus_wdata;
                    SEL_DOP: begin
                        d_op_q    <= bus_wdata;
                        dsk_go    <= 1'b1;
                        dsk_paddr <= d_paddr_q;
                        dsk_block <= d_block_q;
                        dsk_count <= d_count_q;
                    end
                    SEL_OUTCH: begin
                        tty_out_vld  <= 1'b1;
                        tty_out_byte <= bus_wdata[7:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    cons_cpu_table #(.N(CPU_N), .W(DATA_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_wr && dec_sel == SEL_CPUTAB),
        .wr_idx  (dec_idx),
        .wr_data (bus_wdata),
        .rd_idx  (dec_idx),
        .rd_data (tab_rd),
        .go      (cpu_go),
        .go_idx  (cpu_go_idx),
        .go_val  (cpu_go_val)
    );
endmodule

// File: rtl/cons_regblk_chk.sv
module cons_regblk_chk
    import cons_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [SIZE_W-1:0]    bus_size,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [DATA_W-1:0]    rsp_rdata,
    input logic                 tty_out_vld,
    input logic [7:0]           tty_out_byte,
    input logic                 tty_in_pop,
    input logic [7:0]           tty_in_byte,
    input logic                 dsk_go,
    input logic                 cpu_go,
    input logic [DATA_W-1:0]    cpu_go_val
);
    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> rsp_valid);
    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !rsp_valid);
    // R2
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    // R3
    narrow_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_size == 4'd4 && bus_addr >= 10'h010) |=> rsp_err);
    // R11
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !(dsk_go || cpu_go || tty_out_vld || tty_in_pop));
    // R6
    dsk_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_go |-> ($past(bus_wdata) == DISK_READ_CMD));
    // R9
    cpu_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_go |-> (cpu_go_val != '0));
    // R7
    tty_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tty_out_vld |-> (tty_out_byte == $past(bus_wdata[7:0])));
    // R8
    tty_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tty_in_pop |-> (rsp_rdata == {56'd0, $past(tty_in_byte)}));
endmodule

bind cons_regblk cons_regblk_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .tty_out_vld (tty_out_vld),
    .tty_out_byte(tty_out_byte),
    .tty_in_pop  (tty_in_pop),
    .tty_in_byte (tty_in_byte),
    .dsk_go      (dsk_go),
    .cpu_go      (cpu_go),
    .cpu_go_val  (cpu_go_val)
);

// File: tb/cons_regblk_tb.sv
module cons_regblk_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] VER = 32'h0000_0009;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [9:0]  bus_addr = '0;
    logic [3:0]  bus_size = '0;
    logic [63:0] bus_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        prm_load = 0;
    logic [31:0] prm_ncpu = 32'd4, prm_intr_hz = 32'd1024;
    logic [63:0] prm_mem_bytes = 64'h0000_0001_0000_0000, prm_cpu_mhz = 64'd2000;
    logic [63:0] prm_kern_start = 64'hFFFF_FC00_0031_0000;
    logic [63:0] prm_kern_end   = 64'hFFFF_FC00_0088_0000;
    logic [63:0] prm_kern_entry = 64'hFFFF_FC00_0031_0400;
    logic        tty_out_vld, tty_in_pop;
    logic [7:0]  tty_out_byte;
    logic [7:0]  tty_in_byte = 8'h41;
    logic        dsk_go, cpu_go;
    logic [63:0] dsk_paddr, dsk_block, dsk_count, cpu_go_val;
    logic [5:0]  cpu_go_idx;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench-side expected state
    bit          m_loaded = 0;
    logic [63:0] m_dunit = 64'd1, m_dcount = 0, m_dpaddr = 0, m_dblock = 0, m_dop = 0;
    logic [63:0] m_tab [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    cons_regblk #(.VERSION(VER)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .prm_load(prm_load), .prm_ncpu(prm_ncpu), .prm_intr_hz(prm_intr_hz),
        .prm_mem_bytes(prm_mem_bytes), .prm_cpu_mhz(prm_cpu_mhz),
        .prm_kern_start(prm_kern_start), .prm_kern_end(prm_kern_end),
        .prm_kern_entry(prm_kern_entry), .tty_out_vld(tty_out_vld),
        .tty_out_byte(tty_out_byte), .tty_in_pop(tty_in_pop), .tty_in_byte(tty_in_byte),
        .dsk_go(dsk_go), .dsk_paddr(dsk_paddr), .dsk_block(dsk_block),
        .dsk_count(dsk_count), .cpu_go(cpu_go), .cpu_go_idx(cpu_go_idx),
        .cpu_go_val(cpu_go_val)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pval(input logic [9:0] a);
        if (!m_loaded) return 64'd0;
        case (a)
            10'h008: return {32'd0, prm_ncpu};
            10'h00C: return {32'd0, prm_intr_hz};
            10'h010: return prm_mem_bytes;
            10'h018: return prm_cpu_mhz;
            10'h020: return prm_kern_start;
            10'h028: return prm_kern_end;
            10'h030: return prm_kern_entry;
            default: return 64'd0;
        endcase
    endfunction

    // expected response of one access, updating the bench state
    task automatic model(input bit rd, input bit wr, input logic [9:0] a, input logic [3:0] sz,
                         input logic [63:0] wd, output bit e, output logic [63:0] rv,
                         output bit dgo, output bit cgo, output bit ogo, output bit ipop);
        int ai = int'(a);
        bit narrow = (ai == 0 || ai == 4 || ai == 8 || ai == 12);
        bit wide   = (ai >= 'h10 && ai < 'h70 && ai % 8 == 0);
        bit tab    = (ai >= 'h70 && ai < 'h270 && ai % 8 == 0);
        e = 1; rv = 0; dgo = 0; cgo = 0; ogo = 0; ipop = 0;
        if (rd && !wr) begin
            if (sz == 4 && narrow) begin
                e = 0;
                if (ai == 0)      rv = 64'h26F;
                else if (ai == 4) rv = {32'd0, VER};
                else              rv = pval(a);
            end else if (sz == 8 && (wide || tab)) begin
                e = 0;
                if (tab) rv = m_tab[(ai - 'h70) / 8];
                else case (ai)
                    'h38: rv = m_dunit;
                    'h40: rv = m_dcount;
                    'h48: rv = m_dpaddr;
                    'h50: rv = m_dblock;
                    'h58: rv = m_dop;
                    'h60: rv = 0;
                    'h68: begin rv = {56'd0, tty_in_byte}; ipop = 1; end
                    default: rv = pval(a);
                endcase
            end
        end else if (wr && !rd && sz == 8) begin
            if (tab) begin
                if (wd != 0) begin e = 0; cgo = 1; m_tab[(ai - 'h70) / 8] = wd; end
            end else if (wide) begin
                case (ai)
                    'h38: begin e = 0; m_dunit  = wd; end
                    'h40: begin e = 0; m_dcount = wd; end
                    'h48: begin e = 0; m_dpaddr = wd; end
                    'h50: begin e = 0; m_dblock = wd; end
                    'h58: if (wd == 64'h13) begin e = 0; dgo = 1; m_dop = wd; end
                    'h60: begin e = 0; ogo = 1; end
                    default: e = 1;
                endcase
            end
        end
    endtask

    task automatic acc(input bit rd, input bit wr, input logic [9:0] a, input logic [3:0] sz,
                       input logic [63:0] wd, input string tag);
        bit e, dgo, cgo, ogo, ipop;
        logic [63:0] rv;
        logic [63:0] ep = m_dpaddr, eb = m_dblock, ec = m_dcount;
        model(rd, wr, a, sz, wd, e, rv, dgo, cgo, ogo, ipop);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
        chk(tag, "valid", {63'd0, rsp_valid}, 64'd1);
        chk(tag, "err", {63'd0, rsp_err}, {63'd0, e});
        if (rd && !wr && !e) chk(tag, "rdata", rsp_rdata, rv);
        chk(tag, "dsk_go", {63'd0, dsk_go}, {63'd0, dgo});
        if (dgo) begin
            chk(tag, "dsk_paddr", dsk_paddr, ep);
            chk(tag, "dsk_block", dsk_block, eb);
            chk(tag, "dsk_count", dsk_count, ec);
        end
        chk(tag, "cpu_go", {63'd0, cpu_go}, {63'd0, cgo});
        if (cgo) begin
            chk(tag, "cpu_go_idx", {58'd0, cpu_go_idx}, 64'((int'(a) - 'h70) / 8));
            chk(tag, "cpu_go_val", cpu_go_val, wd);
        end
        chk(tag, "tty_out_vld", {63'd0, tty_out_vld}, {63'd0, ogo});
        if (ogo) chk(tag, "tty_out_byte", {56'd0, tty_out_byte}, {56'd0, wd[7:0]});
        chk(tag, "tty_in_pop", {63'd0, tty_in_pop}, {63'd0, ipop});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 64; i++) m_tab[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2", "idle valid", {63'd0, rsp_valid}, 64'd0);

        // R1 reset values
        acc(1, 0, 10'h000, 4, 0, "R1 last offset");
        acc(1, 0, 10'h004, 4, 0, "R1 version");
        acc(1, 0, 10'h038, 8, 0, "R1 disk unit");
        acc(1, 0, 10'h058, 8, 0, "R1 disk op");
        acc(1, 0, 10'h268, 8, 0, "R1 table top");
        acc(1, 0, 10'h010, 8, 0, "R1 params before load");

        // R10 load
        @(negedge clk); prm_load = 1; @(negedge clk); prm_load = 0; m_loaded = 1;
        acc(1, 0, 10'h008, 4, 0, "R10 ncpu");
        acc(1, 0, 10'h00C, 4, 0, "R10 intr");
        acc(1, 0, 10'h010, 8, 0, "R10 mem");
        acc(1, 0, 10'h018, 8, 0, "R10 mhz");
        acc(1, 0, 10'h030, 8, 0, "R10 entry");
        acc(0, 1, 10'h010, 8, 64'hDEAD, "R5 write read-only param");
        acc(1, 0, 10'h010, 8, 0, "R11 param unchanged");

        // R3 R4 R5 legality corners
        acc(1, 0, 10'h010, 4, 0, "R3 narrow read of wide reg");
        acc(1, 0, 10'h000, 8, 0, "R4 wide read of narrow reg");
        acc(1, 0, 10'h038, 2, 0, "R4 bad size");
        acc(1, 0, 10'h270, 8, 0, "R4 past window");
        acc(1, 0, 10'h074, 8, 0, "R4 misaligned");
        acc(1, 1, 10'h038, 8, 5, "R4 both strobes");
        acc(0, 1, 10'h040, 4, 7, "R5 narrow write");
        acc(0, 1, 10'h068, 8, 7, "R5 write input char");
        acc(1, 0, 10'h040, 8, 0, "R11 count unchanged");

        // R12 R6 disk request
        acc(0, 1, 10'h040, 8, 64'd16, "R12 count");
        acc(0, 1, 10'h048, 8, 64'h8000, "R12 paddr");
        acc(0, 1, 10'h050, 8, 64'd77, "R12 block");
        acc(0, 1, 10'h038, 8, 64'd2, "R12 unit");
        acc(1, 0, 10'h048, 8, 0, "R12 paddr readback");
        acc(0, 1, 10'h058, 8, 64'h12, "R6 bad command");
        acc(1, 0, 10'h058, 8, 0, "R11 op unchanged");
        acc(0, 1, 10'h058, 8, 64'h13, "R6 read command");
        acc(1, 0, 10'h058, 8, 0, "R6 op readback");

        // R7 R8 console
        acc(0, 1, 10'h060, 8, 64'h1234_5678_9ABC_DE5A, "R7 out char");
        acc(1, 0, 10'h060, 8, 0, "R7 out char reads zero");
        tty_in_byte = 8'hC3;
        acc(1, 0, 10'h068, 8, 0, "R8 in char");
        acc(1, 0, 10'h068, 4, 0, "R8 narrow in char rejected");

        // R9 table
        acc(0, 1, 10'h070, 8, 64'd0, "R9 zero launch");
        acc(0, 1, 10'h070, 8, 64'h1000, "R9 launch 0");
        acc(0, 1, 10'h268, 8, 64'hABCD, "R9 launch 63");
        acc(1, 0, 10'h268, 8, 0, "R9 readback 63");
        acc(1, 0, 10'h070, 8, 0, "R9 readback 0");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [9:0]  a;
            logic [3:0]  sz;
            logic [63:0] wd;
            bit rd, wr;
            int r = int'($urandom_range(0, 99));
            if (r < 80) a = 10'(4 * $urandom_range(0, 163));
            else        a = 10'($urandom);
            r = int'($urandom_range(0, 9));
            sz = (r < 2) ? 4'd4 : (r < 9) ? 4'd8 : 4'($urandom_range(0, 15));
            r = int'($urandom_range(0, 99));
            rd = (r < 50) || (r >= 96);
            wr = (r >= 50);
            wd = {$urandom, $urandom};
            if (a == 10'h058 && $urandom_range(0, 1) == 1) wd = 64'h13;
            if (a >= 10'h070 && $urandom_range(0, 4) == 0) wd = 0;
            tty_in_byte = 8'($urandom);
            acc(rd, wr, a, sz, wd, "random R3 R4 R5 R6 R9 R12");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule